// File: doc/BRIEF.md
# Cascadable Carry-Lookahead Adder

This block adds two unsigned operands of WIDTH bits plus a one-bit carry-in. It returns the WIDTH-bit sum and the carry-out. The operands are split into 4-bit slices. Each slice forms a generate term (a AND b) and a propagate term (a XOR b) for every bit. It then derives all of its internal carries at once as flat AND-OR expressions, so no carry ripples from bit to bit. Each sum bit is the propagate term XOR the carry into that bit.

Each slice also reports a slice-level generate and propagate pair. A parameter chooses how the slices are linked:
- In chained mode, each slice's carry-out feeds the next slice.
- In lookahead mode, a second-level carry unit forms the carry into every slice directly from the slice-level pairs and the carry-in.

The result is captured in output registers with a synchronous active-high reset, so a sum appears one clock after its operands. WIDTH must be a multiple of 4 and defaults to 8. Tie the carry-in low for plain addition.

Top module: `cla_adder`

## Requirements
- R1: One clock after op_a, op_b and carry_in are sampled with reset low, sum_q equals the low WIDTH bits of op_a + op_b + carry_in.
- R2: In the same cycle, carry_out_q equals bit WIDTH of the (WIDTH+1)-bit value op_a + op_b + carry_in.
- R3: A clock edge with rst high sets sum_q to zero and carry_out_q to 0, whatever the operands are.
- R4: With op_a all ones, op_b zero and carry_in 1, the registered result is sum_q zero with carry_out_q 1.
- R5: A carry born in the low 4-bit slice reaches the next slice: 0x0F + 0x01 with carry_in 0 gives 0x10, and 0x0F + 0x00 with carry_in 1 also gives 0x10.
- R6: When every bit position propagates (op_a XOR op_b all ones), carry_out_q equals the carry_in that was sampled, and sum_q is all ones for carry_in 0 and all zeros for carry_in 1.
- R7: When the top bit of both operands is 1, carry_out_q is 1 regardless of the lower bits and carry_in.
- R8: The chained and lookahead slice-linking variants produce identical sum_q and carry_out_q for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the result registers |
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into the least significant bit |
| sum_q | output | WIDTH | Registered sum, low WIDTH bits |
| carry_out_q | output | 1 | Registered carry out of the top bit |

## Verification
The hardest case to reach is a carry that must cross every slice boundary. In this case the lookahead terms must agree with a full-length ripple, and in the default width only a handful of operand pairs produce it. The stimulus reaches it by sweeping every operand pair with both carry-in values. It also places directed all-propagate and boundary-crossing vectors ahead of the sweep. Both linking variants run side by side on the same inputs against a behavioural sum.

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int SLICE_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } slice_gp_t;

  typedef enum logic {
    LINK_CHAINED   = 1'b0,
    LINK_LOOKAHEAD = 1'b1
  } link_mode_e;

endpackage

// File: rtl/cla_slice4.sv
module cla_slice4
  import cla_pkg::*;
(
  input  logic [SLICE_W-1:0] a,
  input  logic [SLICE_W-1:0] b,
  input  logic               cin,
  output logic [SLICE_W-1:0] sum,
  output slice_gp_t          gp
);

  logic [SLICE_W-1:0] g;
  logic [SLICE_W-1:0] p;
  logic [SLICE_W-1:0] c;

  assign g = a & b;
  assign p = a ^ b;

  // every carry is a flat two-level AND-OR of g, p and cin
  assign c[0] = cin;
  assign c[1] = g[0] | (p[0] & cin);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
              | (p[2] & p[1] & p[0] & cin);

  assign sum = p ^ c;

  assign gp.gen  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                 | (p[3] & p[2] & p[1] & g[0]);
  assign gp.prop = &p;

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int NSLICE = 2
) (
  input  logic [NSLICE-1:0] slice_g,
  input  logic [NSLICE-1:0] slice_p,
  input  logic              cin,
  output logic [NSLICE:0]   carry
);

  // carry[j] = OR over k<j of (g[k] AND p[k+1..j-1]) OR (p[0..j-1] AND cin)
  always_comb begin
    logic acc;
    logic term;
    carry = '0;
    for (int j = 0; j <= NSLICE; j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = slice_g[k];
        for (int m = k + 1; m < j; m++) begin
          term = term & slice_p[m];
        end
        acc = acc | term;
      end
      term = cin;
      for (int m = 0; m < j; m++) begin
        term = term & slice_p[m];
      end
      carry[j] = acc | term;
    end
  end

endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter link_mode_e LINK  = LINK_LOOKAHEAD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_out_q
);

  localparam int NSLICE = WIDTH / SLICE_W;

  slice_gp_t [NSLICE-1:0] gp;
  logic      [NSLICE:0]   slice_cin;
  logic      [NSLICE-1:0] gp_gen;
  logic      [NSLICE-1:0] gp_prop;
  logic      [WIDTH-1:0]  sum_w;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    cla_slice4 u_slice (
      .a   (op_a[i*SLICE_W +: SLICE_W]),
      .b   (op_b[i*SLICE_W +: SLICE_W]),
      .cin (slice_cin[i]),
      .sum (sum_w[i*SLICE_W +: SLICE_W]),
      .gp  (gp[i])
    );
    assign gp_gen[i]  = gp[i].gen;
    assign gp_prop[i] = gp[i].prop;
  end

  if (LINK == LINK_LOOKAHEAD) begin : g_link_la
    cla_carry_unit #(.NSLICE(NSLICE)) u_carry (
      .slice_g (gp_gen),
      .slice_p (gp_prop),
      .cin     (carry_in),
      .carry   (slice_cin)
    );
  end else begin : g_link_chain
    assign slice_cin[0] = carry_in;
    for (genvar i = 0; i < NSLICE; i++) begin : g_hop
      assign slice_cin[i+1] = gp_gen[i] | (gp_prop[i] & slice_cin[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
    end else begin
      sum_q       <= sum_w;
      carry_out_q <= slice_cin[NSLICE];
    end
  end

endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_out_q
);

  logic [WIDTH:0] full_w;
  assign full_w = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  a_r1_sum_value: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sum_q == $past(full_w[WIDTH-1:0]));

  a_r2_carry_value: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> carry_out_q == $past(full_w[WIDTH]));

  a_r3_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_q == '0 && !carry_out_q));

  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a == '1 && op_b == '0 && carry_in))
    |-> (sum_q == '0 && carry_out_q));

  a_r6_all_propagate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(&(op_a ^ op_b)))
    |-> (carry_out_q == $past(carry_in) && sum_q == {WIDTH{!$past(carry_in)}}));

  a_r7_top_generate: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a[WIDTH-1] & op_b[WIDTH-1])) |-> carry_out_q);

endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_cla_adder.sv
module tb_cla_adder;
  import cla_pkg::*;

  localparam int W          = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         cin = 1'b0;
  logic [W-1:0] s_la, s_ch;
  logic         co_la, co_ch;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;
  logic [W:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_adder #(.WIDTH(W), .LINK(LINK_LOOKAHEAD)) dut (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .carry_in(cin),
    .sum_q(s_la), .carry_out_q(co_la));

  cla_adder #(.WIDTH(W), .LINK(LINK_CHAINED)) dut_chain (
    .clk(clk), .rst(rst), .op_a(a), .op_b(b), .carry_in(cin),
    .sum_q(s_ch), .carry_out_q(co_ch));

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // called at a falling edge; result is sampled at the next falling edge
  task automatic apply(logic [W-1:0] va, logic [W-1:0] vb, logic vc, string req);
    logic [W:0] e;
    a   = va;
    b   = vb;
    cin = vc;
    exp_q.push_back(W'(0) + {1'b0, va} + {1'b0, vb} + (W+1)'(vc));
    @(posedge clk);
    @(negedge clk);
    e = exp_q.pop_front();
    check({req, " R1 sum"},   32'(s_la),  32'(e[W-1:0]));
    check({req, " R2 carry"}, 32'(co_la), 32'(e[W]));
    check({req, " R8 chained sum"},   32'(s_ch),  32'(e[W-1:0]));
    check({req, " R8 chained carry"}, 32'(co_ch), 32'(e[W]));
  endtask

  task automatic reset_check(string tag);
    rst = 1'b1;
    a   = 8'hFF;
    b   = 8'hFF;
    cin = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R3 sum"},   32'(s_la),  32'h0);
    check({tag, " R3 carry"}, 32'(co_la), 32'h0);
    check({tag, " R3 chained sum"}, 32'(s_ch), 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reset_check("initial");

    // R4: all ones plus carry-in wraps to zero with carry-out
    apply(8'hFF, 8'h00, 1'b1, "R4");
    apply(8'hFF, 8'hFF, 1'b1, "R4");
    // R5: carry crosses the slice boundary
    apply(8'h0F, 8'h01, 1'b0, "R5");
    apply(8'h0F, 8'h00, 1'b1, "R5");
    // R6: every position propagates
    apply(8'hFF, 8'h00, 1'b0, "R6");
    apply(8'hAA, 8'h55, 1'b1, "R6");
    apply(8'h3C, 8'hC3, 1'b0, "R6");
    // R7: top bits generate
    apply(8'h80, 8'h80, 1'b0, "R7");
    apply(8'hC0, 8'h80, 1'b1, "R7");

    // reset in mid run with busy operands
    reset_check("midrun");

    // exhaustive sweep
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          apply(W'(x), W'(y), c[0], "sweep");
        end
      end
    end

    // randomized tail
    for (int n = 0; n < 400; n++) begin
      apply(W'($urandom), W'($urandom), 1'($urandom), "random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule